// File: doc/BRIEF.md
# Local Interrupt Timer

This block is a down-counting timer that raises a local interrupt through its own vector entry. A free-running tick input is the time base. The ticks are divided by a power-of-two prescale. Software writes three things: a starting count, a prescale shift and a timer entry. The entry holds the interrupt vector, a mask flag and a mode select. The block returns the remaining count at all times. When the count expires it emits a single-cycle interrupt pulse that carries the vector.

There are two modes. In one-shot mode the timer counts down once, fires when it reaches zero and then stays idle at zero. In periodic mode it reloads itself after every expiry, so the period is one more than the starting count. A periodic timer loaded with zero stays silent. A masked timer keeps counting but never fires. Arbitration of the pulse against other interrupt sources belongs to logic outside this block.

Top module: `tick_timer`

## Requirements
- R1: After reset the interrupt output is low, the remaining count reads 0, and the timer entry is masked (bit 16 set), in one-shot mode (bit 17 clear), with vector 0.
- R2: Elapsed units equal the number of ticks since the last count load, shifted right by the prescale shift (0 to 2**SHIFT_W-1). A shift write takes effect for loads made after it.
- R3: Writing the starting count restarts the elapsed measurement from zero, and the remaining count reads the written value in the next cycle.
- R4: In one-shot mode (entry bit 17 = 0) with a nonzero starting count N, the timer fires exactly once, when elapsed units reach N. It then stays idle with the remaining count at 0.
- R5: In one-shot mode a starting count of 0 never fires.
- R6: In periodic mode (entry bit 17 = 1) with starting count N > 0, the timer fires each time elapsed units reach a nonzero multiple of N+1.
- R7: In periodic mode a starting count of 0 never fires, and the remaining count reads 0.
- R8: While entry bit 16 is set, no pulse is produced, but counting continues. Clearing the mask does not restart the count.
- R9: An expiry raises irq_o for exactly one cycle, in the cycle after the tick that caused it. irq_vec_o then holds entry bits 7:0.
- R10: The remaining count reads N minus elapsed units, floored at 0, in one-shot mode, and N minus (elapsed modulo (N+1)) in periodic mode.
- R11: When a count write and a tick arrive in the same cycle, the write wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Time-base tick, one per cycle at most |
| init_wr_i | input | 1 | Write strobe for the starting count |
| init_val_i | input | CNT_W | Starting count |
| shift_wr_i | input | 1 | Write strobe for the prescale shift |
| shift_val_i | input | SHIFT_W | Prescale shift |
| entry_wr_i | input | 1 | Write strobe for the timer entry |
| entry_val_i | input | 18 | Timer entry: bits 7:0 vector, bit 16 mask, bit 17 periodic |
| cur_count_o | output | CNT_W | Remaining count |
| irq_o | output | 1 | Interrupt pulse |
| irq_vec_o | output | 8 | Vector carried by the pulse |

## Verification
Several properties are checked on every cycle. No pulse may appear without a tick in the cycle before it, and none while the previous mask was set or the loaded count was zero. Pulses are never adjacent. The remaining count never exceeds the loaded count, and a count load shows at once on the readback. The cycle-exact expiry points, the modulo reload, one-shot idling, the prescale division across shifts and the write-beats-tick rule are different: they depend on accumulated tick history, so only the bench's reference model can confirm them, over directed and seeded random episodes.

// File: rtl/tt_pkg.sv
package tt_pkg;
   localparam int ENTRY_W  = 18;
   localparam int VEC_W    = 8;
   localparam int MASK_BIT = 16;
   localparam int MODE_BIT = 17;
   localparam logic [ENTRY_W-1:0] ENTRY_RST = 18'h1_0000;

   typedef enum logic {
      MODE_ONESHOT  = 1'b0,
      MODE_PERIODIC = 1'b1
   } tmode_e;

   typedef struct packed {
      logic             masked;
      tmode_e           mode;
      logic [VEC_W-1:0] vec;
   } tcfg_t;
endpackage

// File: rtl/tt_cfg_regs.sv
module tt_cfg_regs
   import tt_pkg::*;
#(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               entry_wr,
   input  logic [ENTRY_W-1:0] entry_val,
   input  logic               shift_wr,
   input  logic [SHIFT_W-1:0] shift_val,
   output tcfg_t              cfg,
   output logic [SHIFT_W-1:0] shift
);
   logic [7:0] unused_rsvd;
   assign unused_rsvd = entry_val[15:8];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg.masked <= ENTRY_RST[MASK_BIT];
         cfg.mode   <= tmode_e'(ENTRY_RST[MODE_BIT]);
         cfg.vec    <= ENTRY_RST[VEC_W-1:0];
      end else if (entry_wr) begin
         cfg.masked <= entry_val[MASK_BIT];
         cfg.mode   <= tmode_e'(entry_val[MODE_BIT]);
         cfg.vec    <= entry_val[VEC_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)        shift <= '0;
      else if (shift_wr) shift <= shift_val;
   end
endmodule

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               restart,
   input  logic               tick,
   input  logic [SHIFT_W-1:0] shift,
   output logic               step
);
   localparam int PRE_W = (1 << SHIFT_W) - 1;

   logic [PRE_W-1:0] pre_q;
   logic [PRE_W-1:0] low_mask;

   for (genvar b = 0; b < PRE_W; b++) begin : g_mask
      assign low_mask[b] = (int'(shift) > b);
   end

   assign step = tick && !restart && ((pre_q & low_mask) == low_mask);

   always_ff @(posedge clk) begin
      if (!rst_n || restart) pre_q <= '0;
      else if (tick)         pre_q <= pre_q + 1'b1;
   end
endmodule

// File: rtl/tt_period_counter.sv
module tt_period_counter
   import tt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             step,
   input  tmode_e           mode,
   output logic [CNT_W-1:0] init_q,
   output logic [CNT_W-1:0] remain,
   output logic             fire
);
   logic [CNT_W-1:0] phase_q;
   logic             at_end;
   logic             will_end;

   assign at_end   = (phase_q == init_q);
   assign will_end = (phase_q + 1'b1 == init_q);
   assign remain   = init_q - phase_q;

   always_comb begin
      fire = 1'b0;
      if (step && init_q != '0) begin
         if (mode == MODE_PERIODIC) fire = at_end;
         else                       fire = !at_end && will_end;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         init_q  <= '0;
         phase_q <= '0;
      end else if (load) begin
         init_q  <= load_val;
         phase_q <= '0;
      end else if (step && init_q != '0) begin
         if (mode == MODE_PERIODIC) phase_q <= at_end ? '0 : phase_q + 1'b1;
         else if (!at_end)          phase_q <= phase_q + 1'b1;
      end
   end
endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tt_pkg::*;
#(
   parameter int CNT_W   = 16,
   parameter int SHIFT_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic               init_wr_i,
   input  logic [CNT_W-1:0]   init_val_i,
   input  logic               shift_wr_i,
   input  logic [SHIFT_W-1:0] shift_val_i,
   input  logic               entry_wr_i,
   input  logic [ENTRY_W-1:0] entry_val_i,
   output logic [CNT_W-1:0]   cur_count_o,
   output logic               irq_o,
   output logic [VEC_W-1:0]   irq_vec_o
);
   if (CNT_W < 2 || CNT_W > 32) begin : g_bad_cnt
      $error("tick_timer: CNT_W out of range");
   end
   if (SHIFT_W < 1 || SHIFT_W > 4) begin : g_bad_shift
      $error("tick_timer: SHIFT_W out of range");
   end

   tcfg_t              cfg;
   logic [SHIFT_W-1:0] shift;
   logic               step;
   logic               fire;
   logic [CNT_W-1:0]   init_q;
   logic               mask_q;
   logic               irq_q;
   logic [VEC_W-1:0]   vec_q;

   tt_cfg_regs #(.SHIFT_W(SHIFT_W)) u_cfg (
      .clk(clk), .rst_n(rst_n),
      .entry_wr(entry_wr_i), .entry_val(entry_val_i),
      .shift_wr(shift_wr_i), .shift_val(shift_val_i),
      .cfg(cfg), .shift(shift)
   );

   tt_prescaler #(.SHIFT_W(SHIFT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .restart(init_wr_i),
      .tick(tick_i), .shift(shift), .step(step)
   );

   tt_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(init_wr_i), .load_val(init_val_i),
      .step(step), .mode(cfg.mode),
      .init_q(init_q), .remain(cur_count_o), .fire(fire)
   );

   assign mask_q = cfg.masked;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         vec_q <= '0;
      end else begin
         irq_q <= fire && !mask_q;
         if (fire && !mask_q) vec_q <= cfg.vec;
      end
   end

   assign irq_o     = irq_q;
   assign irq_vec_o = vec_q;
endmodule

// File: rtl/tick_timer_checker.sv
module tick_timer_checker #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick_i,
   input logic             init_wr_i,
   input logic [CNT_W-1:0] init_val_i,
   input logic [CNT_W-1:0] init_q,
   input logic             mask_q,
   input logic [CNT_W-1:0] cur_count_o,
   input logic             irq_o
);
   assert_pulse_needs_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(tick_i) && !$past(init_wr_i)));

   assert_single_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> !$past(mask_q));

   assert_zero_count_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> ($past(init_q) != '0));

   assert_load_restarts_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(init_wr_i) |-> (cur_count_o == $past(init_val_i)));

   assert_remain_bounded_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cur_count_o <= init_q);
endmodule

bind tick_timer tick_timer_checker #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
   .init_wr_i(init_wr_i), .init_val_i(init_val_i),
   .init_q(init_q), .mask_q(mask_q),
   .cur_count_o(cur_count_o), .irq_o(irq_o)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
   localparam int CNT_W   = 16;
   localparam int SHIFT_W = 3;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               tick_i = 1'b0;
   logic               init_wr_i = 1'b0;
   logic [CNT_W-1:0]   init_val_i = '0;
   logic               shift_wr_i = 1'b0;
   logic [SHIFT_W-1:0] shift_val_i = '0;
   logic               entry_wr_i = 1'b0;
   logic [17:0]        entry_val_i = '0;
   logic [CNT_W-1:0]   cur_count_o;
   logic               irq_o;
   logic [7:0]         irq_vec_o;

   tick_timer #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) uut (.*);

   always #5 clk = ~clk;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   // reference model state
   int m_entry = 32'h1_0000;
   int m_shift = 0;
   int m_init  = 0;
   int m_ticks = 0;

   function automatic bit m_periodic(); return m_entry[17]; endfunction
   function automatic bit m_masked();   return m_entry[16]; endfunction

   function automatic int exp_remain(int el);
      if (m_periodic()) return (m_init == 0) ? 0 : m_init - (el % (m_init + 1));
      return (el >= m_init) ? 0 : m_init - el;
   endfunction

   function automatic string irq_tag();
      if (m_masked())   return "R8";
      if (m_init == 0)  return m_periodic() ? "R7" : "R5";
      return m_periodic() ? "R6" : "R4";
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
      end
   endtask

   // one clock: drive, edge, update model, compare
   task automatic run(bit t, bit ld, int v, bit chk, string rtag);
      int prev_el, el;
      bit exp_fire;
      prev_el = m_ticks >>> m_shift;
      tick_i = t; init_wr_i = ld; init_val_i = CNT_W'(v);
      @(posedge clk); #1;
      tick_i = 0; init_wr_i = 0; shift_wr_i = 0; entry_wr_i = 0;
      if (ld) begin m_init = v; m_ticks = 0; end
      else if (t) m_ticks++;
      el = m_ticks >>> m_shift;
      exp_fire = t && !ld && (el > prev_el) && !m_masked() && m_init != 0 &&
                 (m_periodic() ? (el % (m_init + 1) == 0) : (el == m_init));
      if (chk) begin
         check(irq_o == exp_fire, irq_tag(), int'(irq_o), int'(exp_fire));
         if (exp_fire) check(irq_vec_o == m_entry[7:0], "R9", irq_vec_o, m_entry[7:0]);
         check(cur_count_o == exp_remain(el), rtag, cur_count_o, exp_remain(el));
      end
   endtask

   task automatic wcfg(int e, int s);
      entry_wr_i = 1; entry_val_i = e[17:0];
      shift_wr_i = 1; shift_val_i = s[SHIFT_W-1:0];
      m_entry = e; m_shift = s;
      run(0, 0, 0, 0, "R10");
   endtask

   task automatic wentry(int e);
      entry_wr_i = 1; entry_val_i = e[17:0];
      m_entry = e;
      run(0, 0, 0, 1, "R10");
   endtask

   task automatic ticks(int n, string rtag);
      for (int i = 0; i < n; i++) run(1, 0, 0, 1, rtag);
   endtask

   int fires;

   initial begin
      #1_500_000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1 reset state
      check(irq_o == 0, "R1", irq_o, 0);
      check(cur_count_o == 0, "R1", cur_count_o, 0);
      // R1: default entry is masked one-shot, no pulse
      run(0, 1, 3, 1, "R1");
      ticks(6, "R1");

      // R3: reload restarts
      wcfg(32'h0_0021, 0);
      run(0, 1, 5, 1, "R3");
      ticks(2, "R10");
      check(cur_count_o == 3, "R3", cur_count_o, 3);
      run(0, 1, 5, 1, "R3");
      check(cur_count_o == 5, "R3", cur_count_o, 5);
      ticks(8, "R4");
      check(cur_count_o == 0, "R4", cur_count_o, 0);

      // R11: load and tick together
      run(1, 1, 4, 1, "R11");
      check(cur_count_o == 4, "R11", cur_count_o, 4);
      ticks(5, "R11");

      // R5 one-shot zero
      run(0, 1, 0, 1, "R5");
      ticks(10, "R5");
      // R7 periodic zero
      wcfg(32'h2_0033, 0);
      run(0, 1, 0, 1, "R7");
      ticks(10, "R7");

      // R6 periodic, count pulses
      wcfg(32'h2_0044, 0);
      run(0, 1, 3, 1, "R6");
      fires = 0;
      for (int i = 0; i < 16; i++) begin
         run(1, 0, 0, 1, "R6");
         fires += irq_o;
      end
      check(fires == 4, "R6", fires, 4);

      // R2 prescale shift 2, periodic
      wcfg(32'h2_0055, 2);
      run(0, 1, 2, 1, "R2");
      ticks(30, "R2");
      // R2 max shift, one-shot
      wcfg(32'h0_0066, 7);
      run(0, 1, 1, 1, "R2");
      fires = 0;
      for (int i = 0; i < 300; i++) begin
         run(1, 0, 0, 1, "R2");
         fires += irq_o;
      end
      check(fires == 1, "R2", fires, 1);

      // R8 mask toggle mid-run keeps counting
      wcfg(32'h3_0077, 0);
      run(0, 1, 4, 1, "R8");
      ticks(7, "R8");
      wentry(32'h2_0077);
      ticks(12, "R8");

      // seeded random episodes
      for (int ep = 0; ep < 30; ep++) begin
         int e, s, n;
         e = {14'd0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) == 0),
              8'd0, 8'($urandom)};
         s = $urandom_range(0, 3);
         n = $urandom_range(0, 9);
         wcfg(e, s);
         run(0, 1, n, 1, "R3");
         for (int c = 0; c < 80; c++) begin
            bit t;
            t = ($urandom_range(0, 3) != 0);
            if (c == 40 && $urandom_range(0, 1) == 1) run(t, 1, n, 1, "R11");
            else run(t, 0, 0, 1, "R10");
         end
      end

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule